// File: doc/BRIEF.md
# Operand Handshake Computation Unit

This block supervises one operation at a time on behalf of a variable-latency arithmetic unit. It holds the operation from the moment it is issued until its result has been written back. A single-cycle issue pulse delivers an operation record, and the block answers by raising busy. It then collects each source operand it needs. Every source port has its own release/go pair: the block raises the release, and the operand provider answers with a one-cycle go that carries the data.

Once every needed operand has been gathered, the record is handed to the arithmetic unit over a valid/ready stream. The unit's result comes back over a second valid/ready stream. The block then requests a write-back slot using the same release/go handshake as the reads, and busy drops once that slot is granted.

Any source can be suppressed, so that it is never requested. A per-port read mask does this for any port. A zero flag does it for port 0, which then reads as zero. An immediate flag does it for the last port, which then reads as the immediate value.

Back-pressure rules:
- Toward the arithmetic unit, `alu_valid_o` stays high, with the opcode and operands unchanged, until `alu_ready_i` is seen high at a clock edge.
- Toward the result stream, `res_ready_o` is high only while the block is waiting for a result. A beat transfers on the edge where `res_valid_i` and `res_ready_o` are both high.

Top module: `opnd_track_cu`

## Requirements
- R1: While reset is held and after its release, `busy_o`, `rd_rel_o`, `alu_valid_o`, `res_ready_o` and `wr_rel_o` are all low.
- R2: `busy_o` rises only in the cycle after `issue_i` was high with the block idle. It is low during that issue cycle, and it is never high in the same cycle as `issue_i`.
- R3: The opcode, mask, zero flag, immediate flag and immediate value are captured in the issue cycle. Changing those inputs afterwards does not alter the operation. The opcode is forwarded unchanged on `alu_op_o`.
- R4: For each port that is not suppressed, `rd_rel_o[i]` rises in the cycle after issue. It stays high through any number of stall cycles until `rd_go_i[i]` is seen.
- R5: `rd_go_i[i]` may be driven high in the very cycle `rd_rel_o[i]` is first high. Source data is taken from `src_i` slice i (bits i*DATA_W upward) in the go cycle only. `rd_rel_o[i]` falls in the next cycle and does not rise again until the next issue.
- R6: A port with read-mask bit i set raises no release and reads as zero. Port 0 with the zero flag set raises no release and reads as zero. The last port with the immediate flag set raises no release and reads as the immediate value. The immediate takes precedence over that port's mask bit.
- R7: `alu_valid_o` rises in the cycle in which the last outstanding release falls, or in the cycle after issue when no operand is needed. It stays high with `alu_op_o` and `alu_opnd_o` (slice i = port i) held stable until `alu_ready_i`.
- R8: `res_ready_o` is high from the cycle after the arithmetic unit accepts until `res_valid_i` is seen. `res_data_i` is captured at that edge.
- R9: `wr_rel_o` rises in the cycle after the result is captured. It stays high until `wr_go_i`, with `wr_data_o` holding the captured result.
- R10: `busy_o` falls in the cycle after `wr_go_i` is seen with `wr_rel_o` high. With prompt peers, an operation completes within 50 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | One-cycle issue pulse |
| op_i | input | OP_W | Opcode of the issued operation |
| rd_mask_i | input | NUM_SRC | Per-port read suppression |
| zero_a_i | input | 1 | Port 0 reads as zero, no request |
| imm_ok_i | input | 1 | Last port takes the immediate, no request |
| imm_i | input | DATA_W | Immediate value |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | NUM_SRC | Per-port read request |
| rd_go_i | input | NUM_SRC | Per-port read grant, one cycle |
| src_i | input | NUM_SRC*DATA_W | Source data, valid with its go |
| alu_valid_o | output | 1 | Operation offered to the arithmetic unit |
| alu_ready_i | input | 1 | Arithmetic unit accepts |
| alu_op_o | output | OP_W | Captured opcode |
| alu_opnd_o | output | NUM_SRC*DATA_W | Gathered operands |
| res_valid_i | input | 1 | Result offered |
| res_ready_o | output | 1 | Block accepts the result |
| res_data_i | input | DATA_W | Result data |
| wr_rel_o | output | 1 | Write-back request |
| wr_go_i | input | 1 | Write-back grant, one cycle |
| wr_data_o | output | DATA_W | Result for write-back |

## Verification
Operations are issued with both ports read promptly, with stalls of several cycles before one port's grant, and with the second port served first. These runs separate correct holding of a release from an early drop, and correct per-port data capture from a swapped or mistimed capture. Suppression patterns follow: zero-A alone, immediate alone, both together, a single mask bit, both mask bits, and the immediate combined with its port's mask bit. Each one shows whether a suppressed port raises a request and which value it supplies. Record inputs are scrambled after every issue, and latencies on the arithmetic and write-back sides are varied, so that late sampling and lost back-pressure show up as wrong results queued in the scoreboard.

// File: rtl/otc_pkg.sv
package otc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_EXEC  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_WRITE = 3'd4
  } cu_state_e;
endpackage

// File: rtl/otc_src_port.sv
module otc_src_port #(
  parameter int DATA_W  = 16,
  parameter bit ZERO_EN = 1'b0,
  parameter bit IMM_EN  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mask_i,
  input  logic              zero_a_i,
  input  logic              imm_ok_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              go_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              need_o,
  output logic              rel_o,
  output logic [DATA_W-1:0] opnd_o
);
  logic              by_imm;
  logic              by_zero;
  logic [DATA_W-1:0] preset;

  // immediate replaces the port even when its mask bit is set
  assign by_imm  = IMM_EN && imm_ok_i;
  assign by_zero = ZERO_EN && zero_a_i;
  assign need_o  = !mask_i && !by_zero && !by_imm;
  assign preset  = by_imm ? imm_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_o  <= 1'b0;
      opnd_o <= '0;
    end else if (start_i) begin
      rel_o  <= need_o;
      opnd_o <= preset;
    end else if (rel_o && go_i) begin
      rel_o  <= 1'b0;
      opnd_o <= src_i;
    end
  end
endmodule

// File: rtl/otc_sequencer.sv
module otc_sequencer import otc_pkg::*; #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_i,
  input  logic               need_any_i,
  input  logic [NUM_SRC-1:0] rel_i,
  input  logic [NUM_SRC-1:0] go_i,
  input  logic               alu_ready_i,
  input  logic               res_valid_i,
  input  logic               wr_go_i,
  output logic               start_o,
  output logic               busy_o,
  output logic               alu_valid_o,
  output logic               res_ready_o,
  output logic               wr_rel_o
);
  cu_state_e state_q;
  cu_state_e state_d;

  assign start_o = issue_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_o) state_d = need_any_i ? ST_READ : ST_EXEC;
      ST_READ:  if ((rel_i & ~go_i) == '0) state_d = ST_EXEC;
      ST_EXEC:  if (alu_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (res_valid_i) state_d = ST_WRITE;
      ST_WRITE: if (wr_go_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign alu_valid_o = (state_q == ST_EXEC);
  assign res_ready_o = (state_q == ST_WAIT);
  assign wr_rel_o    = (state_q == ST_WRITE);
endmodule

// File: rtl/otc_result_hold.sv
module otc_result_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      data_o <= '0;
    else if (take_i) data_o <= data_i;
  end
endmodule

// File: rtl/opnd_track_cu.sv
module opnd_track_cu #(
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 2,
  parameter int OP_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue_i,
  input  logic [OP_W-1:0]           op_i,
  input  logic [NUM_SRC-1:0]        rd_mask_i,
  input  logic                      zero_a_i,
  input  logic                      imm_ok_i,
  input  logic [DATA_W-1:0]         imm_i,
  output logic                      busy_o,
  output logic [NUM_SRC-1:0]        rd_rel_o,
  input  logic [NUM_SRC-1:0]        rd_go_i,
  input  logic [NUM_SRC*DATA_W-1:0] src_i,
  output logic                      alu_valid_o,
  input  logic                      alu_ready_i,
  output logic [OP_W-1:0]           alu_op_o,
  output logic [NUM_SRC*DATA_W-1:0] alu_opnd_o,
  input  logic                      res_valid_i,
  output logic                      res_ready_o,
  input  logic [DATA_W-1:0]         res_data_i,
  output logic                      wr_rel_o,
  input  logic                      wr_go_i,
  output logic [DATA_W-1:0]         wr_data_o
);
  localparam int ZERO_PORT = 0;
  localparam int IMM_PORT  = NUM_SRC - 1;

  logic               start;
  logic [NUM_SRC-1:0] need;
  logic [OP_W-1:0]    op_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_port
    otc_src_port #(
      .DATA_W (DATA_W),
      .ZERO_EN(g == ZERO_PORT),
      .IMM_EN (g == IMM_PORT)
    ) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .mask_i  (rd_mask_i[g]),
      .zero_a_i(zero_a_i),
      .imm_ok_i(imm_ok_i),
      .imm_i   (imm_i),
      .go_i    (rd_go_i[g]),
      .src_i   (src_i[g*DATA_W +: DATA_W]),
      .need_o  (need[g]),
      .rel_o   (rd_rel_o[g]),
      .opnd_o  (alu_opnd_o[g*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     op_q <= '0;
    else if (start) op_q <= op_i;
  end
  assign alu_op_o = op_q;

  otc_sequencer #(.NUM_SRC(NUM_SRC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .need_any_i (|need),
    .rel_i      (rd_rel_o),
    .go_i       (rd_go_i),
    .alu_ready_i(alu_ready_i),
    .res_valid_i(res_valid_i),
    .wr_go_i    (wr_go_i),
    .start_o    (start),
    .busy_o     (busy_o),
    .alu_valid_o(alu_valid_o),
    .res_ready_o(res_ready_o),
    .wr_rel_o   (wr_rel_o)
  );

  otc_result_hold #(.DATA_W(DATA_W)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .take_i(res_valid_i && res_ready_o),
    .data_i(res_data_i),
    .data_o(wr_data_o)
  );
endmodule

// File: rtl/otc_checker.sv
module otc_checker #(
  parameter int DATA_W   = 16,
  parameter int NUM_SRC  = 2,
  parameter int OP_W     = 4,
  parameter int MAX_BUSY = 50
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      issue_i,
  input logic                      busy_o,
  input logic [NUM_SRC-1:0]        rd_rel_o,
  input logic [NUM_SRC-1:0]        rd_go_i,
  input logic                      alu_valid_o,
  input logic                      alu_ready_i,
  input logic [OP_W-1:0]           alu_op_o,
  input logic [NUM_SRC*DATA_W-1:0] alu_opnd_o,
  input logic                      res_ready_o,
  input logic                      wr_rel_o,
  input logic                      wr_go_i,
  input logic [DATA_W-1:0]         wr_data_o
);
  localparam int CNT_W = $clog2(MAX_BUSY + 2) + 1;
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy_o) busy_cnt <= '0;
    else if (busy_cnt <= CNT_W'(MAX_BUSY)) busy_cnt <= busy_cnt + 1'b1;
  end

  p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(issue_i));
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && issue_i));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rel
    p_rel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rel_o[g] && !rd_go_i[g]) |=> rd_rel_o[g]);
    p_rel_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rel_o[g] && rd_go_i[g]) |=> !rd_rel_o[g]);
    p_rel_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_rel_o[g]) |-> $past(issue_i));
  end

  p_alu_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid_o && !alu_ready_i) |=>
      (alu_valid_o && $stable(alu_op_o) && $stable(alu_opnd_o)));
  p_alu_after_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid_o |-> (rd_rel_o == '0));
  p_res_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready_o |-> (busy_o && !alu_valid_o && !wr_rel_o));
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rel_o && !wr_go_i) |=> (wr_rel_o && $stable(wr_data_o)));
  p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rel_o && wr_go_i) |=> !busy_o);
  p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNT_W'(MAX_BUSY));
endmodule

bind opnd_track_cu otc_checker #(
  .DATA_W (DATA_W),
  .NUM_SRC(NUM_SRC),
  .OP_W   (OP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_i    (issue_i),
  .busy_o     (busy_o),
  .rd_rel_o   (rd_rel_o),
  .rd_go_i    (rd_go_i),
  .alu_valid_o(alu_valid_o),
  .alu_ready_i(alu_ready_i),
  .alu_op_o   (alu_op_o),
  .alu_opnd_o (alu_opnd_o),
  .res_ready_o(res_ready_o),
  .wr_rel_o   (wr_rel_o),
  .wr_go_i    (wr_go_i),
  .wr_data_o  (wr_data_o)
);

// File: tb/tb_opnd_track_cu.sv
`timescale 1ns/100ps
module tb_opnd_track_cu;
  localparam int DW = 16;
  localparam int NS = 2;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_i = 1'b0;
  logic [OW-1:0] op_i = '0;
  logic [NS-1:0] rd_mask_i = '0;
  logic          zero_a_i = 1'b0;
  logic          imm_ok_i = 1'b0;
  logic [DW-1:0] imm_i = '0;
  logic          busy_o;
  logic [NS-1:0] rd_rel_o;
  logic [NS-1:0] rd_go_i = '0;
  logic [NS*DW-1:0] src_i = '0;
  logic          alu_valid_o;
  logic          alu_ready_i = 1'b0;
  logic [OW-1:0] alu_op_o;
  logic [NS*DW-1:0] alu_opnd_o;
  logic          res_valid_i = 1'b0;
  logic          res_ready_o;
  logic [DW-1:0] res_data_i = '0;
  logic          wr_rel_o;
  logic          wr_go_i = 1'b0;
  logic [DW-1:0] wr_data_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  opnd_track_cu #(.DATA_W(DW), .NUM_SRC(NS), .OP_W(OW)) dut (.*);

  function automatic logic [DW-1:0] alu_fn(input logic [OW-1:0] op,
                                           input logic [DW-1:0] a, b);
    case (op[1:0])
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a ^ b;
      default: return a & b;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor side of the scoreboard: compares each written-back result
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (wr_go_i && wr_rel_o) begin
        if (exp_q.size() == 0) chk("R9 unexpected write-back", 32'(wr_data_o), 32'hFFFF_FFFF);
        else chk("R3/R9 written result", 32'(wr_data_o), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic serve(input int i, input bit need, input int dly, input logic [DW-1:0] data);
    if (!need) return;
    for (int k = 0; k < dly; k++) begin
      chk("R4 release held in stall", 32'(rd_rel_o[i]), 32'd1);
      @(negedge clk);
    end
    chk("R4 release before go", 32'(rd_rel_o[i]), 32'd1);
    rd_go_i[i] = 1'b1;
    src_i[i*DW +: DW] = data;
    @(negedge clk);
    rd_go_i[i] = 1'b0;
    src_i = '1;
    chk("R5 release falls after go", 32'(rd_rel_o[i]), 32'd0);
  endtask

  task automatic run_op(input logic [OW-1:0] op, input logic [DW-1:0] a, b,
                        input logic [NS-1:0] mask, input bit imm_ok, input logic [DW-1:0] imm,
                        input bit zero_a, input int d0, d1, lat, wdly, input bit b_first);
    bit n0, n1;
    logic [DW-1:0] ea, eb, res;
    int t0;
    n0 = !mask[0] && !zero_a;
    n1 = !mask[1] && !imm_ok;
    ea = n0 ? a : '0;
    eb = imm_ok ? imm : (n1 ? b : '0);
    exp_q.push_back(alu_fn(op, ea, eb));   // driver side of the scoreboard
    @(negedge clk);
    t0 = 0;
    issue_i = 1'b1; op_i = op; rd_mask_i = mask; imm_ok_i = imm_ok; imm_i = imm; zero_a_i = zero_a;
    chk("R2 busy low in issue cycle", 32'(busy_o), 32'd0);
    @(negedge clk);
    issue_i = 1'b0; op_i = ~op; rd_mask_i = ~mask; imm_ok_i = ~imm_ok; imm_i = ~imm; zero_a_i = ~zero_a;
    chk("R2 busy after issue", 32'(busy_o), 32'd1);
    chk("R4/R6 releases after issue", 32'(rd_rel_o), 32'({n1, n0}));
    if (b_first) begin
      serve(1, n1, d1, b);
      serve(0, n0, d0, a);
    end else begin
      serve(0, n0, d0, a);
      serve(1, n1, d1, b);
    end
    chk("R7 alu valid once reads done", 32'(alu_valid_o), 32'd1);
    chk("R6 operand port 0", 32'(alu_opnd_o[0 +: DW]), 32'(ea));
    chk("R6 operand port 1", 32'(alu_opnd_o[DW +: DW]), 32'(eb));
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R7 alu valid held", 32'(alu_valid_o), 32'd1);
    end
    res = alu_fn(alu_op_o, alu_opnd_o[0 +: DW], alu_opnd_o[DW +: DW]);
    alu_ready_i = 1'b1;
    @(negedge clk);
    alu_ready_i = 1'b0;
    chk("R8 result ready after accept", 32'(res_ready_o), 32'd1);
    chk("R7 alu valid dropped", 32'(alu_valid_o), 32'd0);
    for (int k = 0; k < lat; k++) @(negedge clk);
    chk("R8 result ready held", 32'(res_ready_o), 32'd1);
    res_valid_i = 1'b1; res_data_i = res;
    @(negedge clk);
    res_valid_i = 1'b0; res_data_i = '0;
    chk("R8 result ready dropped", 32'(res_ready_o), 32'd0);
    chk("R9 write release", 32'(wr_rel_o), 32'd1);
    for (int k = 0; k < wdly; k++) begin
      @(negedge clk);
      chk("R9 write release held", 32'(wr_rel_o), 32'd1);
    end
    wr_go_i = 1'b1;
    @(negedge clk);
    wr_go_i = 1'b0;
    chk("R10 busy falls after write go", 32'(busy_o), 32'd0);
    chk("R5 no release after op", 32'(rd_rel_o), 32'd0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 read releases", 32'(rd_rel_o), 32'd0);
    chk("R1 alu valid", 32'(alu_valid_o), 32'd0);
    chk("R1 result ready", 32'(res_ready_o), 32'd0);
    chk("R1 write release", 32'(wr_rel_o), 32'd0);
    //      op     a        b        mask  imm imm_v    zA d0 d1 lat wd bfirst
    run_op(4'd0, 16'd5,   16'd2,   2'b00, 0, 16'h0,   0, 0, 0, 0, 0, 0);
    run_op(4'd1, 16'd300, 16'd45,  2'b00, 0, 16'h0,   0, 0, 3, 2, 2, 0);
    run_op(4'd2, 16'hA5A5,16'h0FF0,2'b00, 0, 16'h0,   0, 4, 1, 1, 3, 1);
    run_op(4'd0, 16'd9,   16'd7,   2'b00, 0, 16'h0,   1, 0, 2, 0, 0, 0);
    run_op(4'd1, 16'd50,  16'd7,   2'b00, 1, 16'd13,  0, 1, 0, 3, 1, 0);
    run_op(4'd0, 16'd50,  16'd7,   2'b00, 1, 16'h1234,1, 0, 0, 1, 0, 0);
    run_op(4'd3, 16'hFFFF,16'h00F0,2'b10, 0, 16'h0,   0, 2, 0, 0, 1, 0);
    run_op(4'd0, 16'd77,  16'd88,  2'b11, 0, 16'h0,   0, 0, 0, 2, 0, 0);
    run_op(4'd0, 16'd4,   16'd99,  2'b10, 1, 16'd40,  0, 1, 0, 0, 0, 0);
    run_op(4'd1, 16'd1,   16'd2,   2'b01, 0, 16'h0,   0, 0, 5, 4, 2, 1);
    repeat (3) @(negedge clk);
    chk("R2 busy stays low without issue", 32'(busy_o), 32'd0);
    chk("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule